// File: doc/BRIEF.md
# Opcode-Selected Arithmetic and Logic Unit

This block is a purely combinational arithmetic-logic unit for a datapath of parameterized width `WIDTH` (default 32). A 4-bit opcode picks one of six operations on two operands: three bitwise functions (AND, OR, NOR), addition, subtraction, and a signed less-than compare. The opcode space is sparse. Every code outside the six defined ones gives a fixed, well-defined output.

Addition and subtraction are computed one bit wider than the operands. The extra bit is brought out as a carry/borrow flag. The compare reuses the subtractor's difference and places its one-bit answer in bit 0 of an otherwise zero result word. A zero flag reports whether the selected result word is all zeros. The block holds no state and has no clock. The parameter `WIDTH` must be 2 or more.

Top module: `opcode_alu`

## Requirements
- R1: Opcode 0 (4'b0000) drives result_o = a_i & b_i and carry_o = 0.
- R2: Opcode 1 (4'b0001) drives result_o = a_i | b_i and carry_o = 0.
- R3: Opcode 12 (4'b1100) drives result_o = ~(a_i | b_i) and carry_o = 0.
- R4: Opcode 2 (4'b0010) forms the WIDTH+1 bit unsigned sum of a_i and b_i. The low WIDTH bits of the sum go to result_o and bit WIDTH goes to carry_o.
- R5: Opcode 6 (4'b0110) drives result_o = a_i + ~b_i + 1, truncated to WIDTH bits. carry_o is 1 exactly when a_i < b_i as unsigned numbers (a borrow occurred).
- R6: Opcode 7 (4'b0111) compares a_i and b_i as signed two's-complement values. result_o is 1 when a_i < b_i and 0 otherwise, with bits WIDTH-1..1 always 0. carry_o = 0.
- R7: Every other opcode (3, 4, 5, 8 to 11, 13 to 15) drives result_o = 0 and carry_o = 0.
- R8: zero_o is 1 exactly when all WIDTH bits of result_o are 0, for every opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation select code |
| result_o | output | WIDTH | Selected result word |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry out of add, borrow out of subtract, else 0 |

## Verification
The bench targets four kinds of corner case.

- **Wrapping add.** It applies adds that wrap exactly to zero, such as all-ones plus one and two most-negative values. A design that sized the sum to the operands would lose the carry and leave carry_o low.
- **Borrow polarity.** It applies subtractions with equal operands and with a zero minuend. A design that exported the raw adder carry would invert the borrow flag.
- **Signed compare.** It pairs the most negative value against the most positive value and against small positive values, where the difference overflows. A compare that looked only at the sign of the difference, or compared unsigned, returns the wrong answer there.
- **Undefined opcodes.** It sweeps every undefined opcode with all-ones operands. This shows up a decoder whose default branch passes through a live result or leaves a stale carry.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd6,
    OP_SLT = 4'd7,
    OP_NOR = 4'd12
  } alu_op_e;
endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);
  logic [WIDTH-1:0] or_w;

  always_comb begin
    or_w  = a_i | b_i;
    and_o = a_i & b_i;
    or_o  = or_w;
    nor_o = ~or_w;
  end
endmodule

// File: rtl/alu_addsub.sv
// Shared WIDTH+1 bit adder: sub_i selects a + ~b + 1 with a high extension bit on b,
// so bit WIDTH of the sum is the add carry or the subtract borrow.
module alu_addsub #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH:0]   sum_o
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] x_w;
  logic [EW-1:0] y_w;

  always_comb begin
    x_w = {1'b0, a_i};
    y_w = {sub_i, b_i ^ {WIDTH{sub_i}}};
  end

  generate
    if (RIPPLE) begin : g_ripple
      logic [EW-1:0] c_w;
      assign c_w[0] = sub_i;
      for (genvar i = 0; i < EW; i++) begin : g_bit
        assign sum_o[i] = x_w[i] ^ y_w[i] ^ c_w[i];
        if (i < EW - 1) begin : g_cy
          assign c_w[i+1] = (x_w[i] & y_w[i]) | (c_w[i] & (x_w[i] ^ y_w[i]));
        end
      end
    end else begin : g_behav
      assign sum_o = x_w + y_w + {{WIDTH{1'b0}}, sub_i};
    end
  endgenerate
endmodule

// File: rtl/alu_slt.sv
// Signed less-than from the subtractor: sign of difference corrected by overflow.
module alu_slt (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic d_msb_i,
  output logic lt_o
);
  logic ovf_w;

  always_comb begin
    ovf_w = (a_msb_i ^ b_msb_i) & (d_msb_i ^ a_msb_i);
    lt_o  = d_msb_i ^ ovf_w;
  end
endmodule

// File: rtl/opcode_alu.sv
module opcode_alu #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [WIDTH-1:0]          a_i,
  input  logic [WIDTH-1:0]          b_i,
  input  logic [alu_pkg::OP_W-1:0]  op_i,
  output logic [WIDTH-1:0]          result_o,
  output logic                      zero_o,
  output logic                      carry_o
);
  import alu_pkg::*;

  logic [WIDTH-1:0] and_w, or_w, nor_w;
  logic [WIDTH:0]   sum_w;
  logic             sub_w;
  logic             lt_w;

  assign sub_w = (op_i == OP_SUB) || (op_i == OP_SLT);

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i  (a_i),
    .b_i  (b_i),
    .and_o(and_w),
    .or_o (or_w),
    .nor_o(nor_w)
  );

  alu_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_addsub (
    .a_i  (a_i),
    .b_i  (b_i),
    .sub_i(sub_w),
    .sum_o(sum_w)
  );

  alu_slt u_slt (
    .a_msb_i(a_i[WIDTH-1]),
    .b_msb_i(b_i[WIDTH-1]),
    .d_msb_i(sum_w[WIDTH-1]),
    .lt_o   (lt_w)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    case (op_i)
      OP_AND: result_o = and_w;
      OP_OR:  result_o = or_w;
      OP_NOR: result_o = nor_w;
      OP_ADD: begin
        result_o = sum_w[WIDTH-1:0];
        carry_o  = sum_w[WIDTH];
      end
      OP_SUB: begin
        result_o = sum_w[WIDTH-1:0];
        carry_o  = sum_w[WIDTH];
      end
      OP_SLT: result_o = {{(WIDTH-1){1'b0}}, lt_w};
      default: begin
        result_o = '0;
        carry_o  = 1'b0;
      end
    endcase
    zero_o = ~|result_o;
  end
endmodule

// File: rtl/opcode_alu_checker.sv
module opcode_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             zero_o,
  input logic             carry_o
);
  logic known_w;
  assign known_w = !$isunknown({a_i, b_i, op_i});

  always_comb begin
    if (known_w) begin
      if (op_i == 4'd0)
        assert_and_R1: assert (result_o == (a_i & b_i) && !carry_o);
      if (op_i == 4'd1)
        assert_or_R2: assert (result_o == (a_i | b_i) && !carry_o);
      if (op_i == 4'd12)
        assert_nor_R3: assert (result_o == ~(a_i | b_i) && !carry_o);
      if (op_i == 4'd2)
        assert_add_R4: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
      if (op_i == 4'd6)
        assert_sub_R5: assert (result_o == a_i - b_i && carry_o == (a_i < b_i));
      if (op_i == 4'd7)
        assert_slt_R6: assert (!carry_o &&
          result_o == (($signed(a_i) < $signed(b_i)) ? WIDTH'(1) : WIDTH'(0)));
      if (!(op_i inside {4'd0, 4'd1, 4'd2, 4'd6, 4'd7, 4'd12}))
        assert_undef_R7: assert (result_o == '0 && !carry_o);
      assert_zero_R8: assert (zero_o == (result_o == '0));
    end
  end
endmodule

bind opcode_alu opcode_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .result_o(result_o),
  .zero_o  (zero_o),
  .carry_o (carry_o)
);

// File: tb/opcode_alu_bench.sv
module opcode_alu_bench;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] res;
    logic         cy;
    logic         zr;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{4'd0,  32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234, 1'b0, 1'b0}, // R1
    '{4'd0,  32'hAAAA_AAAA, 32'h5555_5555, 32'h0000_0000, 1'b0, 1'b1}, // R1
    '{4'd1,  32'h1200_0034, 32'h0045_6700, 32'h1245_6734, 1'b0, 1'b0}, // R2
    '{4'd12, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0}, // R3
    '{4'd12, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1}, // R3
    '{4'd2,  32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 1'b0, 1'b0}, // R4
    '{4'd2,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1}, // R4
    '{4'd2,  32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1}, // R4
    '{4'd6,  32'h0000_0005, 32'h0000_0003, 32'h0000_0002, 1'b0, 1'b0}, // R5
    '{4'd6,  32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R5
    '{4'd6,  32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 1'b0, 1'b1}, // R5
    '{4'd6,  32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0}, // R5
    '{4'd7,  32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0}, // R6
    '{4'd7,  32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b1}, // R6
    '{4'd7,  32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0}, // R6
    '{4'd7,  32'h0000_0005, 32'h0000_0005, 32'h0000_0000, 1'b0, 1'b1}, // R6
    '{4'd7,  32'h8000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0}, // R6
    '{4'd3,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1}, // R7
    '{4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b1}, // R7
    '{4'd5,  32'h1234_5678, 32'h8765_4321, 32'h0000_0000, 1'b0, 1'b1}  // R7
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [3:0]   op_i = '0;
  logic [W-1:0] result_o;
  logic         zero_o, carry_o;
  int           n_vec = 0, n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  opcode_alu #(.WIDTH(W)) u_opcode_alu (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0:    return "R1";
      4'd1:    return "R2";
      4'd12:   return "R3";
      4'd2:    return "R4";
      4'd6:    return "R5";
      4'd7:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] res, output logic cy);
    logic [W:0] s;
    res = '0;
    cy  = 1'b0;
    case (op)
      4'd0:  res = a & b;
      4'd1:  res = a | b;
      4'd12: res = ~(a | b);
      4'd2: begin
        s = {1'b0, a} + {1'b0, b};
        res = s[W-1:0];
        cy = s[W];
      end
      4'd6: begin
        res = a - b;
        cy = (a < b);
      end
      4'd7:  res = ($signed(a) < $signed(b)) ? W'(1) : W'(0);
      default: ;
    endcase
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] er, input logic ec, input logic ez);
    @(posedge clk);
    op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    n_vec++;
    if (result_o !== er || carry_o !== ec) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: result=%h carry=%b expected result=%h carry=%b",
               req_of(op), op, a, b, result_o, carry_o, er, ec);
    end
    if (zero_o !== ez) begin
      n_bad++;
      $display("FAIL R8 op=%0d a=%h b=%h: zero=%b expected %b", op, a, b, zero_o, ez);
    end
  endtask

  task automatic apply_model(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    logic ec;
    model(op, a, b, er, ec);
    apply(op, a, b, er, ec, er == '0);
  endtask

  initial begin
    logic [W-1:0] edges [5];
    edges = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0001};

    // reset-time state: all-zero inputs select AND, result 0 so zero_o high (R1, R8)
    repeat (2) @(negedge clk);
    n_vec++;
    if (result_o !== '0 || carry_o !== 1'b0 || zero_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 reset: result=%h carry=%b zero=%b expected 0 0 1",
               result_o, carry_o, zero_o);
    end
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++)
      apply(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].res, TBL[i].cy, TBL[i].zr);

    // edge operand cross product over every opcode (R1..R8)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          apply_model(op[3:0], edges[i], edges[j]);

    // random operands, every opcode
    for (int k = 0; k < 1600; k++)
      apply_model(4'(k % 16), $urandom, $urandom);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule